// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block maps a physical address onto one of several memory banks. Each bank is described by a 32-bit configuration word that holds three things: a base address at 8 MiB granularity, a 3-bit power-of-two size code, and an enable bit. On every cycle the block compares the presented address with each bank window. One clock later it reports whether a bank was hit, which bank it was, and the offset of the address inside that bank.

Software loads the configuration words through a small write port. Bits that carry no meaning are cleared by a fixed mask before the word is stored. A combinational peek port reads back any stored word, so the effect of the mask can be seen. A global controller-enable input gates all decoding. While it is low, no address hits any bank.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After reset every stored configuration word reads as zero and the outputs `hit_o`, `bank_o` and `offset_o` are all zero.
- R2: A write stores `cfg_wdata & 32'hFFDEE001` into word `cfg_idx` at the clock edge. From that edge onward, `peek_data` shows the stored value whenever `peek_idx` selects that word.
- R3: The base address of a bank is its stored word ANDed with `32'hFF800000`. Bits 22 and below of the word never move the window.
- R4: The size code is bits [19:17] of the word. Codes 0 to 6 give a bank size of 4 MiB shifted left by the code, so 4 MiB up to 256 MiB.
- R5: A bank whose size code is 7 never hits.
- R6: A bank takes part in decoding only while bit 0 of its word is 1.
- R7: While `ctrl_en` is 0, no bank hits.
- R8: An address hits a bank when (address − base), taken modulo 2^32, is less than the bank size. An address below the base misses, and so does the address base + size.
- R9: On a hit, `offset_o` equals address − base. On a miss, `hit_o`, `bank_o` and `offset_o` are all zero.
- R10: When several banks hit, the bank with the lowest index is reported.
- R11: The outputs show the decode of the address, configuration and `ctrl_en` present before the previous rising clock edge. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Global decode enable |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_idx | input | IDX_W | Index of the word being written |
| cfg_wdata | input | 32 | Raw value written (masked before storing) |
| peek_idx | input | IDX_W | Index of the word shown on `peek_data` |
| peek_data | output | 32 | Stored configuration word selected by `peek_idx` |
| addr_i | input | 32 | Physical address to decode |
| hit_o | output | 1 | Registered: some bank matched |
| bank_o | output | IDX_W | Registered: index of the matching bank |
| offset_o | output | 28 | Registered: address minus bank base |

## Verification
The bench builds the decoder with the default of four banks. With four banks, one bank can cover the whole window of another, so lowest-index priority is tested by removing the winner and watching the next bank take over. The tests reach both size extremes, 4 MiB and 256 MiB, along with both edges of each window. They also cover the invalid size code, a base word with stray low bits set, and the one-cycle output latency.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
    localparam int unsigned REG_W         = 32;
    localparam logic [31:0] WR_KEEP_MASK  = 32'hFFDEE001;
    localparam logic [31:0] BASE_MASK     = 32'hFF800000;
    localparam int unsigned CODE_LSB      = 17;
    localparam int unsigned CODE_W        = 3;
    localparam int unsigned MIN_SIZE_LOG2 = 22;
    localparam logic [2:0]  CODE_BAD      = 3'd7;
    localparam int unsigned MAX_GOOD_CODE = 6;
    localparam int unsigned OFS_W         = MIN_SIZE_LOG2 + MAX_GOOD_CODE;
endpackage

// File: rtl/bank_cfg_store.sv
module bank_cfg_store
    import sdram_dec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                widx,
    input  logic [REG_W-1:0]                wdata,
    output logic [NUM_BANKS-1:0][REG_W-1:0] cfg_q
);
    logic [NUM_BANKS-1:0][REG_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (we && (widx == IDX_W'(i))) begin
                cfg_d[i] = wdata & WR_KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/bank_window_match.sv
module bank_window_match
    import sdram_dec_pkg::*;
(
    input  logic [REG_W-1:0] cfg,
    input  logic [REG_W-1:0] addr,
    input  logic             ctrl_en,
    output logic             match,
    output logic [OFS_W-1:0] offset
);
    logic [CODE_W-1:0] code;
    logic [REG_W-1:0]  base;
    logic [REG_W-1:0]  diff;
    logic [REG_W-1:0]  above;
    logic [4:0]        shamt;

    always_comb begin
        code   = cfg[CODE_LSB +: CODE_W];
        base   = cfg & BASE_MASK;
        diff   = addr - base;
        shamt  = 5'(MIN_SIZE_LOG2) + 5'(code);
        above  = diff >> shamt;
        match  = ctrl_en && cfg[0] && (code != CODE_BAD) && (above == '0);
        offset = diff[OFS_W-1:0];
    end
endmodule

// File: rtl/bank_priority_pick.sv
module bank_priority_pick
    import sdram_dec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic [NUM_BANKS-1:0]            match,
    input  logic [NUM_BANKS-1:0][OFS_W-1:0] offsets,
    output logic                            any,
    output logic [IDX_W-1:0]                idx,
    output logic [OFS_W-1:0]                ofs
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        ofs = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                ofs = offsets[i];
            end
        end
    end
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
    import sdram_dec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_wdata,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [31:0]      peek_data,
    input  logic [31:0]      addr_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] bank_o,
    output logic [27:0]      offset_o
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] bank;
        logic [OFS_W-1:0] ofs;
    } dec_t;

    logic [NUM_BANKS-1:0][REG_W-1:0] bank_cfg;
    logic [NUM_BANKS-1:0]            bank_match;
    logic [NUM_BANKS-1:0][OFS_W-1:0] bank_ofs;
    logic                            pick_any;
    logic [IDX_W-1:0]                pick_idx;
    logic [OFS_W-1:0]                pick_ofs;
    dec_t                            dec_d, dec_q;

    bank_cfg_store #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (cfg_wdata),
        .cfg_q (bank_cfg)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_window_match u_match (
            .cfg     (bank_cfg[g]),
            .addr    (addr_i),
            .ctrl_en (ctrl_en),
            .match   (bank_match[g]),
            .offset  (bank_ofs[g])
        );
    end

    bank_priority_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
        .match   (bank_match),
        .offsets (bank_ofs),
        .any     (pick_any),
        .idx     (pick_idx),
        .ofs     (pick_ofs)
    );

    always_comb begin
        dec_d      = dec_q;
        dec_d.hit  = pick_any;
        dec_d.bank = pick_idx;
        dec_d.ofs  = pick_ofs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign peek_data = bank_cfg[peek_idx];
    assign hit_o     = dec_q.hit;
    assign bank_o    = dec_q.bank;
    assign offset_o  = dec_q.ofs;
endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk
    import sdram_dec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ctrl_en,
    input logic [31:0]                     peek_data,
    input logic                            hit_o,
    input logic [IDX_W-1:0]                bank_o,
    input logic [27:0]                     offset_o,
    input logic [NUM_BANKS-1:0][REG_W-1:0] bank_cfg
);
    logic [NUM_BANKS-1:0] en_prev;
    logic [NUM_BANKS-1:0] code_ok_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev      <= '0;
            code_ok_prev <= '0;
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                en_prev[i]      <= bank_cfg[i][0];
                code_ok_prev[i] <= (bank_cfg[i][CODE_LSB +: CODE_W] != CODE_BAD);
            end
        end
    end

    always_comb begin
        if (rst_n) begin
            AST_PEEK_MASKED: assert ((peek_data & ~WR_KEEP_MASK) == 32'h0); // R2
        end
    end

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !hit_o); // R7

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (bank_o == '0 && offset_o == '0)); // R9

    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> en_prev[bank_o]); // R6

    AST_HIT_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> code_ok_prev[bank_o]); // R5
endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .peek_data (peek_data),
    .hit_o     (hit_o),
    .bank_o    (bank_o),
    .offset_o  (offset_o),
    .bank_cfg  (bank_cfg)
);

// File: tb/sdram_bank_decoder_test.sv
module sdram_bank_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [IW-1:0] peek_idx = '0;
    logic [31:0]   peek_data;
    logic [31:0]   addr_i = '0;
    logic          hit_o;
    logic [IW-1:0] bank_o;
    logic [27:0]   offset_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow [NB];

    sdram_bank_decoder #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .addr_i(addr_i), .hit_o(hit_o), .bank_o(bank_o), .offset_o(offset_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected decode from the requirements (R3..R10)
    task automatic model(input logic [31:0] a, input logic en,
                         output logic h, output logic [IW-1:0] b, output logic [27:0] o);
        h = 1'b0; b = '0; o = '0;
        for (int i = 0; i < NB; i++) begin
            logic [31:0] w, base, diff, size;
            logic [2:0] code;
            w    = shadow[i];
            code = w[19:17];
            base = w & 32'hFF800000;
            diff = a - base;
            size = 32'h0040_0000 << code;
            if (!h && en && w[0] && code != 3'd7 && diff < size) begin
                h = 1'b1; b = IW'(i); o = diff[27:0];
            end
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[idx] = v & 32'hFFDEE001;
    endtask

    task automatic probe(input string req, input logic [31:0] a);
        logic h; logic [IW-1:0] b; logic [27:0] o;
        @(negedge clk);
        addr_i = a;
        model(a, ctrl_en, h, b, o);
        @(posedge clk);
        #1;
        check({req, " hit"}, 64'(hit_o), 64'(h));
        check({req, " bank"}, 64'(bank_o), 64'(b));
        check({req, " offset"}, 64'(offset_o), 64'(o));
    endtask

    task automatic t_reset();
        for (int i = 0; i < NB; i++) begin
            peek_idx = IW'(i);
            #1;
            check("R1 peek", 64'(peek_data), 64'h0);
        end
        check("R1 hit", 64'(hit_o), 64'h0);
        check("R1 bank", 64'(bank_o), 64'h0);
        check("R1 offset", 64'(offset_o), 64'h0);
    endtask

    task automatic t_mask();
        wr(0, 32'hFFFF_FFFF);
        peek_idx = 2'd0; #1;
        check("R2 masked all-ones", 64'(peek_data), 64'hFFDEE001);
        wr(1, 32'h0021_1FFE);
        peek_idx = 2'd1; #1;
        check("R2 masked stray bits", 64'(peek_data), 64'h0);
        // code 7, enabled, ctrl on: bank0 must not hit (R5)
        ctrl_en = 1'b1;
        probe("R5 code7", 32'hFF80_0000);
        check("R5 no hit", 64'(hit_o), 64'h0);
        wr(0, 32'h0); wr(1, 32'h0);
    endtask

    task automatic t_windows();
        ctrl_en = 1'b1;
        wr(0, 32'h0000_0001);                       // base 0, 4 MiB
        probe("R8 bank0 first", 32'h0000_0000);
        probe("R9 bank0 last", 32'h003F_FFFF);
        check("R9 last offset", 64'(offset_o), 64'h3FFFFF);
        probe("R8 bank0 end", 32'h0040_0000);
        check("R8 end miss", 64'(hit_o), 64'h0);
        wr(1, 32'h100C_0001);                       // base 0x1000_0000, 256 MiB
        probe("R4 big first", 32'h1000_0000);
        probe("R4 big last", 32'h1FFF_FFFF);
        check("R4 big bank", 64'(bank_o), 64'h1);
        probe("R8 big end", 32'h2000_0000);
        probe("R8 below base", 32'h0FFF_FFFF);
        check("R8 below miss", 64'(hit_o), 64'h0);
        wr(2, 32'h04A2_0001);                       // base bits 22..21 ignored, 8 MiB
        probe("R3 base lowbits", 32'h0480_0000);
        check("R3 offset zero", 64'(offset_o), 64'h0);
        probe("R3 top", 32'h04FF_FFFF);
        check("R3 top bank", 64'(bank_o), 64'h2);
        probe("R3 past", 32'h0500_0000);
    endtask

    task automatic t_priority();
        ctrl_en = 1'b1;
        wr(3, 32'h0002_0001);                       // base 0, 8 MiB overlaps bank0
        probe("R10 overlap", 32'h0000_0100);
        check("R10 lowest wins", 64'(bank_o), 64'h0);
        wr(0, 32'h0000_0000);
        probe("R10 next wins", 32'h0000_0100);
        check("R10 bank3", 64'(bank_o), 64'h3);
        probe("R10 beyond bank0", 32'h0050_0000);
        wr(3, 32'h0002_0000);                       // disabled
        probe("R6 disabled", 32'h0000_0100);
        check("R6 no hit", 64'(hit_o), 64'h0);
    endtask

    task automatic t_ctrl_and_latency();
        ctrl_en = 1'b1;
        probe("R11 prime", 32'h1234_5678);
        check("R11 prime hit", 64'(hit_o), 64'h1);
        @(negedge clk);
        addr_i = 32'h3000_0000;
        #1;
        check("R11 held before edge", 64'(offset_o), 64'h0234_5678);
        @(posedge clk); #1;
        check("R11 updated after edge", 64'(hit_o), 64'h0);
        ctrl_en = 1'b0;
        probe("R7 ctrl off", 32'h1234_5678);
        check("R7 no hit", 64'(hit_o), 64'h0);
        ctrl_en = 1'b1;
        probe("R7 ctrl back", 32'h1234_5678);
        check("R7 hit again", 64'(hit_o), 64'h1);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_windows();
        t_priority();
        t_ctrl_and_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule